// File: doc/BRIEF.md
# Oversampling UART Receiver with Dual-Rate Mode

This block is an asynchronous serial receiver. It watches a single receive line and, using a sample-enable pulse (`os_tick`) from an external baud generator, takes several samples of the line in each bit period. The `dbl_mode` input picks the oversampling ratio. Low selects normal operation with 16 samples per bit. High selects double-speed operation with 8 samples per bit. The baud generator is expected to run its tick at the matching rate.

While `rx_en` is high, the receiver looks for a high-to-low transition on the synchronised line. It then votes on three samples near the middle of the start bit. If the start bit is confirmed, the internal sample counter is aligned to that edge. This happens again on every frame, so the small timing error never builds up over a stream of bytes. Each of the eight data bits and the stop bit is decided by the same three-sample vote. At the end of the stop bit the byte appears on `rx_data` with a one-cycle `rx_valid` pulse. A stop bit that votes low also raises `rx_ferr` in the same cycle.

A change of `dbl_mode` or a drop of `rx_en` while a frame is in progress abandons that frame without a strobe.

Top module: `uart_os_rx`

## Requirements
- R1: With `dbl_mode`=0 a bit period is 16 `os_tick` pulses, and with `dbl_mode`=1 it is 8. The ratio in force for a frame is the one present on its starting tick.
- R2: A frame can only start on an `os_tick` while `rx_en`=1 and the synchronised line is low, when it was high on the previous tick. That tick counts as sample 1 of the start bit. With `rx_en`=0 no frame is started.
- R3: The start bit is confirmed when at least two of samples 8, 9 and 10 (normal) or samples 4, 5 and 6 (double speed) are low. Otherwise the frame is dropped with no `rx_valid`, and the search for a falling edge resumes.
- R4: Sample counting is realigned on every confirmed start bit. A falling edge on the tick right after the last sample of a stop bit starts a new frame, and that frame is received correctly.
- R5: The eight data bits arrive least significant first, and `rx_data[0]` is the first bit after the start bit. Each bit takes the majority value of the same three sample positions as the start bit. A single disagreeing sample among the three does not change the bit, and two disagreeing samples flip it.
- R6: The stop bit is voted like a data bit. If it votes low, `rx_ferr`=1 in the `rx_valid` cycle, otherwise `rx_ferr`=0. `rx_ferr` is never high without `rx_valid`.
- R7: `rx_valid` is a single-cycle pulse in the clock cycle after the stop bit's last tick. `rx_data` keeps the byte until the next `rx_valid`.
- R8: If `rx_en` falls, or `dbl_mode` differs from the value latched at the start, while a frame is in progress, the frame is abandoned and no `rx_valid` follows for it.
- R9: After synchronous reset (`rst_n`=0), `rx_valid`=0, `rx_ferr`=0 and `rx_data`=0, and the line history reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| dbl_mode | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| os_tick | input | 1 | One-cycle sample enable from the baud generator |
| rx_in | input | 1 | Asynchronous serial receive line, idles high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte on rx_data |
| rx_ferr | output | 1 | Framing error, valid with rx_valid |

## Verification
The hardest cases to reach from the ports are the ones where disagreeing samples fall exactly on the three voting positions. Examples are a start pulse that is low for only the first half of the bit, or a data bit with one or two flipped mid-bit samples. Another is a mode or enable change at a known point inside a frame. The bench makes these reachable by generating `os_tick` itself and setting the line once per tick. It therefore knows the index of every sample relative to the falling edge, and can place flips, glitches and aborts on chosen samples in both ratios.

// File: rtl/uart_os_rx_pkg.sv
// Shared types for the oversampling receiver.
package uart_os_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_os_rx_sync.sv
// Multi-flop synchroniser for the asynchronous receive line.
// Assumes the line idles high; all stages reset to one so no false edge
// is seen on leaving reset.
module uart_os_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // shift the raw line through the synchroniser stages
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_timer.sv
// Per-bit sample counter. Counts os_tick samples inside the current bit,
// flags the three voting samples around the middle and the final sample.
// Assumes nsamp is even and stays constant while active.
module uart_os_rx_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clr,
    input  logic          tick,
    input  logic          active,
    input  logic [CW-1:0] nsamp,
    output logic          vote_hit,
    output logic          bit_end
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic [CW-1:0] mid;

    // index of the sample taken on this tick and the first vote position
    assign nxt = cnt + CW'(1);
    assign mid = nsamp >> 1;

    // decode the voting window and the last sample of the bit
    assign vote_hit = tick && active && (nxt >= mid) && (nxt <= mid + CW'(2));
    assign bit_end  = tick && active && (nxt == nsamp);

    // hold the index of the last sample taken in the current bit
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (clr)             cnt <= '0;
        else if (load)            cnt <= CW'(1);
        else if (bit_end)         cnt <= '0;
        else if (tick && active)  cnt <= nxt;
    end

    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < nsamp));
endmodule

// File: rtl/uart_os_rx_vote.sv
// Three-sample majority voter. Counts high samples captured in the
// current bit; the majority is high when two or more were high.
// Assumes at most three captures between clears.
module uart_os_rx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cap,
    input  logic smp,
    output logic maj
);
    logic [1:0] highs;

    // accumulate high samples at the voting positions
    always_ff @(posedge clk) begin
        if (!rst_n)          highs <= '0;
        else if (clr)        highs <= '0;
        else if (cap && smp) highs <= highs + 2'd1;
    end

    assign maj = (highs >= 2'd2);
endmodule

// File: rtl/uart_os_rx.sv
// Oversampling UART receiver, 1 start, DATA_BITS data (LSB first), 1 stop.
// Samples on each os_tick; dbl_mode picks OS_NORM or OS_FAST samples per
// bit. Start bit and every later bit are decided by a three-sample vote
// around mid-bit. The mode is latched per frame; changing it or dropping
// rx_en mid-frame abandons the frame. Assumes os_tick is a one-cycle pulse.
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OS_NORM     = 16,
    parameter int OS_FAST     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 dbl_mode,
    input  logic                 os_tick,
    input  logic                 rx_in,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_ferr
);
    localparam int CW   = $clog2(OS_NORM + 1);
    localparam int IDXW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    rx_state_t             state;
    logic                  mode_q;
    logic                  last_smp;
    logic [IDXW-1:0]       bit_idx;
    logic [DATA_BITS-1:0]  shreg;
    logic                  line_s;
    logic                  mode_act;
    logic [CW-1:0]         nsamp;
    logic                  edge_go;
    logic                  abort;
    logic                  active;
    logic                  vote_hit;
    logic                  bit_end;
    logic                  maj;

    uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (line_s)
    );

    // ratio in force: live input while idle, latched value during a frame
    assign mode_act = (state == RX_IDLE) ? dbl_mode : mode_q;
    assign nsamp    = mode_act ? CW'(OS_FAST) : CW'(OS_NORM);

    // frame start, abort and activity qualifiers
    assign edge_go = (state == RX_IDLE) && rx_en && os_tick && last_smp && !line_s;
    assign abort   = (state != RX_IDLE) && (!rx_en || (dbl_mode != mode_q));
    assign active  = (state != RX_IDLE) && !abort;

    uart_os_rx_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (edge_go),
        .clr      (abort),
        .tick     (os_tick),
        .active   (active),
        .nsamp    (nsamp),
        .vote_hit (vote_hit),
        .bit_end  (bit_end)
    );

    uart_os_rx_vote u_vote (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bit_end || edge_go || abort),
        .cap   (vote_hit),
        .smp   (line_s),
        .maj   (maj)
    );

    // remember the line level at the previous sample tick for edge search
    always_ff @(posedge clk) begin
        if (!rst_n)       last_smp <= 1'b1;
        else if (os_tick) last_smp <= line_s;
    end

    // frame sequencer: start check, data shift, stop check and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            mode_q   <= 1'b0;
            bit_idx  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
            if (abort) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (edge_go) begin
                            state  <= RX_START;
                            mode_q <= dbl_mode;
                        end
                    end
                    RX_START: begin
                        if (bit_end) begin
                            bit_idx <= '0;
                            state   <= maj ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        if (bit_end) begin
                            shreg <= {maj, shreg[DATA_BITS-1:1]};
                            if (bit_idx == IDXW'(DATA_BITS - 1)) state <= RX_STOP;
                            else bit_idx <= bit_idx + IDXW'(1);
                        end
                    end
                    RX_STOP: begin
                        if (bit_end) begin
                            rx_data  <= shreg;
                            rx_valid <= 1'b1;
                            rx_ferr  <= !maj;
                            state    <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_valid_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state) == RX_STOP));

    assert_ferr_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |-> rx_valid);

    assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == RX_IDLE) && !rx_valid);

    assert_start_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && bit_end && maj && !abort) |=> (state == RX_IDLE));

    assert_no_search_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !rx_en) |=> (state == RX_IDLE));
endmodule

// File: tb/uart_os_rx_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: the bench owns the sample tick and drives the line one
// sample per tick; frame tasks push expected bytes, a monitor pops them.
module uart_os_rx_bench;
    localparam int TDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_en;
    logic       dbl_mode;
    logic       os_tick;
    logic       rx_in;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ferr;

    int total = 0;
    int bad = 0;
    int valid_cnt = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    uart_os_rx u_uart_os_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .dbl_mode (dbl_mode),
        .os_tick  (os_tick),
        .rx_in    (rx_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // one sample period: set the line, then pulse the tick on the last cycle
    task automatic smp(input logic v);
        for (int i = 0; i < TDIV; i++) begin
            @(negedge clk);
            if (i == 0) rx_in = v;
            os_tick = (i == TDIV - 1);
        end
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) smp(v);
    endtask

    function automatic int nsp();
        return dbl_mode ? 8 : 16;
    endfunction

    function automatic int midp();
        return dbl_mode ? 4 : 8;
    endfunction

    // one bit with optional flipped samples at 1-based positions f1, f2
    task automatic bitx(input logic v, input int f1, input int f2);
        for (int k = 1; k <= nsp(); k++) smp((k == f1 || k == f2) ? ~v : v);
    endtask

    // full frame; flips f1 on every bit, f2 on data bits only
    task automatic frame(input logic [7:0] b, input logic stopv, input int f1,
                         input int f2, input logic [7:0] expb, input bit push,
                         input string tag);
        if (push) begin
            exp_q.push_back({~stopv, expb});
            tag_q.push_back(tag);
        end
        bitx(1'b0, f1, 0);
        for (int i = 0; i < 8; i++) bitx(b[i], f1, f2);
        bitx(stopv, f1, 0);
    endtask

    // scoreboard monitor: compare each strobe with the oldest expectation
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rx_valid === 1'b1) begin
            valid_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected rx_valid", int'(rx_data), 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rx_data == e[7:0], t, "rx_data", int'(rx_data), int'(e[7:0]));
                chk(rx_ferr == e[8], t, "rx_ferr", int'(rx_ferr), int'(e[8]));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        rst_n = 1'b0; rx_en = 1'b0; dbl_mode = 1'b0; os_tick = 1'b0; rx_in = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R9", "reset rx_valid", int'(rx_valid), 0);
        chk(rx_ferr == 1'b0, "R9", "reset rx_ferr", int'(rx_ferr), 0);
        chk(rx_data == 8'h00, "R9", "reset rx_data", int'(rx_data), 0);

        rx_en = 1'b1;
        hold(1'b1, 4);
        // R1 R5 normal ratio, R4 back-to-back frames
        frame(8'h55, 1'b1, 0, 0, 8'h55, 1'b1, "R1");
        frame(8'hA3, 1'b1, 0, 0, 8'hA3, 1'b1, "R4");
        frame(8'h00, 1'b1, 0, 0, 8'h00, 1'b1, "R5");
        hold(1'b1, 3);
        frame(8'hFF, 1'b1, 0, 0, 8'hFF, 1'b1, "R5");
        hold(1'b1, 5);
        // R6 low stop bit
        frame(8'h96, 1'b0, 0, 0, 8'h96, 1'b1, "R6");
        hold(1'b1, 5);
        // R5 one flipped vote keeps the bit; two flipped votes invert it
        frame(8'h5A, 1'b1, 8, 0, 8'h5A, 1'b1, "R5");
        frame(8'h0F, 1'b1, 8, 9, 8'hF0, 1'b1, "R5");
        hold(1'b1, 5);
        // R3 start low only up to the first vote sample: rejected
        c0 = valid_cnt;
        for (int k = 1; k <= 16; k++) smp(k <= 8 ? 1'b0 : 1'b1);
        hold(1'b1, 40);
        chk(valid_cnt == c0, "R3", "strobes after rejected start", valid_cnt, c0);
        frame(8'h71, 1'b1, 0, 0, 8'h71, 1'b1, "R3");
        hold(1'b1, 5);

        // R1 double-speed ratio
        dbl_mode = 1'b1;
        hold(1'b1, 4);
        frame(8'h3C, 1'b1, 0, 0, 8'h3C, 1'b1, "R1");
        frame(8'h81, 1'b1, 0, 0, 8'h81, 1'b1, "R4");
        hold(1'b1, 3);
        frame(8'hE7, 1'b0, 0, 0, 8'hE7, 1'b1, "R6");
        hold(1'b1, 3);
        frame(8'h24, 1'b1, midp(), 0, 8'h24, 1'b1, "R5");
        frame(8'hC5, 1'b1, 6, 5, 8'h3A, 1'b1, "R5");
        hold(1'b1, 3);
        c0 = valid_cnt;
        for (int k = 1; k <= 8; k++) smp(k <= 4 ? 1'b0 : 1'b1);
        hold(1'b1, 30);
        chk(valid_cnt == c0, "R3", "strobes after rejected start (x8)", valid_cnt, c0);

        // R8 mode change mid-frame
        c0 = valid_cnt;
        hold(1'b0, 8);
        hold(1'b0, 24);
        dbl_mode = 1'b0;
        hold(1'b1, 60);
        chk(valid_cnt == c0, "R8", "strobes after mode abort", valid_cnt, c0);
        chk(rx_data == 8'h3A, "R7", "rx_data held", int'(rx_data), 8'h3A);
        frame(8'hC3, 1'b1, 0, 0, 8'hC3, 1'b1, "R8");
        hold(1'b1, 4);

        // R8 enable drop mid-frame
        c0 = valid_cnt;
        hold(1'b0, 16);
        hold(1'b1, 16);
        hold(1'b0, 10);
        rx_en = 1'b0;
        hold(1'b1, 20);
        rx_en = 1'b1;
        hold(1'b1, 40);
        chk(valid_cnt == c0, "R8", "strobes after enable abort", valid_cnt, c0);

        // R2 a full frame while disabled is ignored
        rx_en = 1'b0;
        frame(8'h99, 1'b1, 0, 0, 8'h99, 1'b0, "R2");
        hold(1'b1, 4);
        rx_en = 1'b1;
        hold(1'b1, 20);
        chk(valid_cnt == c0, "R2", "strobes while disabled", valid_cnt, c0);
        frame(8'h5E, 1'b1, 0, 0, 8'h5E, 1'b1, "R2");
        hold(1'b1, 4);

        chk(exp_q.size() == 0, "R7", "pending expected bytes", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule